// File: doc/BRIEF.md
# Cursor Visibility and Fetch Configurator

This block turns the programmed state of a hardware cursor into the handful of values that the cursor fetch and display logic need. From the cursor's horizontal position, its hotspot, the viewport's start and width, and the cursor's width, it finds the signed horizontal offset of the cursor inside the viewport. It decides whether any part of the cursor falls inside the viewport, and it produces a destination offset that is never negative.

From the cursor width, the surface pitch in pixels and the colour mode, it also derives the encoded pitch and the lines-per-chunk fetch setting. A cursor whose surface address is still zero is never shown, and its position is not taken up.

Software sets the inputs freely and then pulses a commit strobe. All outputs are registered and change only in the clock cycle that follows that strobe, so a half-written set of inputs never reaches the display path.

Top module: `cursor_cfg`

## Requirements
- R1: While reset is asserted and after it is released without a commit, every output is zero.
- R2: Outputs change only on the clock edge at which `commit_i` is high, so they are visible one cycle after the strobe. In every other cycle they hold.
- R3: The source offset is `pos_x_i - hot_x_i - vp_x_i`, computed signed. `dst_off_o` is this offset when it is zero or positive, and 0 when it is negative.
- R4: The cursor is hidden when the source offset is greater than or equal to `vp_w_i`. An offset of `vp_w_i - 1` is still visible.
- R5: The cursor is hidden when the source offset plus `cur_w_i` is below zero. A sum of exactly zero is still visible.
- R6: `show_o` is 1 only when `en_i` is 1, both edge tests pass and `surf_addr_i` is nonzero.
- R7: On a commit with `surf_addr_i` equal to zero, `show_o` becomes 0 and `dst_off_o` keeps its previous value. The pitch and chunk outputs still update.
- R8: `pitch_code_o` encodes a pitch of 64 pixels as 0, 128 as 1 and 256 as 2. Any other pitch gives code 0 with `pitch_err_o` set to 1. `pitch_err_o` is 0 for the three legal pitches.
- R9: When `mono_i` is 1, `lpc_code_o` is 4 (16 lines) whatever the width.
- R10: When `mono_i` is 0, `lpc_code_o` depends on `cur_w_i` as follows: 4 (16 lines) for widths up to 32, 3 (8 lines) up to 64, 2 (4 lines) up to 128, and 1 (2 lines) above 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | One-cycle strobe that takes up all inputs |
| en_i | input | 1 | Software cursor enable |
| surf_addr_i | input | 48 | Cursor surface address; zero means not yet set |
| pos_x_i | input | 13 | Cursor x position, signed |
| hot_x_i | input | 13 | Hotspot x, signed |
| vp_x_i | input | 13 | Viewport start x, signed |
| vp_w_i | input | 13 | Viewport width, unsigned |
| cur_w_i | input | 9 | Cursor width in pixels, unsigned |
| pitch_i | input | 9 | Surface pitch in pixels |
| mono_i | input | 1 | Monochrome colour mode |
| show_o | output | 1 | Cursor shown |
| dst_off_o | output | 14 | Source offset clamped at zero |
| pitch_code_o | output | 2 | Encoded pitch |
| pitch_err_o | output | 1 | Pitch not one of 64, 128 or 256 |
| lpc_code_o | output | 3 | Encoded lines per chunk |

## Verification
On every cycle the assertions check the following:
- The outputs hold between commits.
- A zero surface address or a cleared software enable forces the cursor off.
- A zero surface address freezes the destination offset.
- Monochrome mode and very wide cursors select the right chunk codes.
- A pitch of 128 encodes cleanly.

The exact offset arithmetic, the boundary cases at both viewport edges, the full width-to-chunk table and the error flag for illegal pitches can only be shown by the bench's scenarios. The bench compares each committed result against values it computes from the requirements.

// File: rtl/cursor_cfg_pkg.sv
package cursor_cfg_pkg;
   // encoded pitch values consumed by the fetch logic
   typedef enum logic [1:0] {
      PITCH_64  = 2'd0,
      PITCH_128 = 2'd1,
      PITCH_256 = 2'd2
   } pitch_code_e;

   // encoded lines-per-chunk values
   typedef enum logic [2:0] {
      LPC_NONE = 3'd0,
      LPC_2    = 3'd1,
      LPC_4    = 3'd2,
      LPC_8    = 3'd3,
      LPC_16   = 3'd4
   } lpc_code_e;
endpackage

// File: rtl/cursor_edge_cull.sv
// Signed source offset, viewport culling and clamped destination offset.
module cursor_edge_cull #(
   parameter int CW = 13,
   parameter int WW = 9
) (
   input  logic signed [CW-1:0] pos_x,
   input  logic signed [CW-1:0] hot_x,
   input  logic signed [CW-1:0] vp_x,
   input  logic        [CW-1:0] vp_w,
   input  logic        [WW-1:0] cur_w,
   output logic        [CW:0]   dst_off,
   output logic                 in_view
);
   localparam int SW = CW + 2;

   if (SW <= WW + 1) begin : g_bad_width
      $error("cursor_edge_cull: coordinate width too small for cursor width");
   end

   logic signed [SW-1:0] src;
   logic signed [SW-1:0] right_lim;
   logic signed [SW-1:0] width_ext;
   logic signed [SW-1:0] left_sum;

   always_comb begin
      src       = $signed({{2{pos_x[CW-1]}}, pos_x})
                - $signed({{2{hot_x[CW-1]}}, hot_x})
                - $signed({{2{vp_x[CW-1]}}, vp_x});
      right_lim = $signed({2'b00, vp_w});
      width_ext = $signed({{(SW-WW){1'b0}}, cur_w});
      left_sum  = src + width_ext;
      in_view   = (src < right_lim) && (left_sum >= 0);
      dst_off   = src[SW-1] ? '0 : src[CW:0];
   end
endmodule

// File: rtl/cursor_fetch_enc.sv
// Pitch encoding and width-dependent lines-per-chunk selection.
module cursor_fetch_enc
   import cursor_cfg_pkg::*;
#(
   parameter int WW        = 9,
   parameter int PW        = 9,
   parameter int LEVELS    = 3,
   parameter int BASE_LOG2 = 5
) (
   input  logic [WW-1:0] cur_w,
   input  logic [PW-1:0] pitch,
   input  logic          mono,
   output logic [1:0]    pitch_code,
   output logic          pitch_err,
   output logic [2:0]    lpc_code
);
   if (PW < 9) begin : g_bad_pw
      $error("cursor_fetch_enc: pitch width must hold 256");
   end
   if (LEVELS < 1 || LEVELS > 6) begin : g_bad_levels
      $error("cursor_fetch_enc: LEVELS out of range");
   end
   if (BASE_LOG2 + LEVELS - 1 >= WW + 1) begin : g_bad_base
      $error("cursor_fetch_enc: width threshold exceeds width range");
   end

   // fits[k]: width no larger than 2^(BASE_LOG2+k)
   logic [LEVELS-1:0] fits;

   for (genvar k = 0; k < LEVELS; k++) begin : g_thr
      localparam int LIM = 1 << (BASE_LOG2 + k);
      assign fits[k] = ({1'b0, cur_w} <= (WW+1)'(LIM));
   end

   always_comb begin
      lpc_code = 3'(LPC_2);
      for (int k = LEVELS - 1; k >= 0; k--) begin
         if (fits[k]) lpc_code = 3'(LEVELS + 1 - k);
      end
      if (mono) lpc_code = 3'(LEVELS + 1);
   end

   always_comb begin
      pitch_err = 1'b0;
      case (pitch)
         PW'(64):  pitch_code = PITCH_64;
         PW'(128): pitch_code = PITCH_128;
         PW'(256): pitch_code = PITCH_256;
         default: begin
            pitch_code = PITCH_64;
            pitch_err  = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/cursor_cfg.sv
// Cursor visibility and fetch configurator: registered on commit.
module cursor_cfg #(
   parameter int CW = 13,
   parameter int WW = 9,
   parameter int PW = 9,
   parameter int AW = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit_i,
   input  logic                 en_i,
   input  logic [AW-1:0]        surf_addr_i,
   input  logic signed [CW-1:0] pos_x_i,
   input  logic signed [CW-1:0] hot_x_i,
   input  logic signed [CW-1:0] vp_x_i,
   input  logic [CW-1:0]        vp_w_i,
   input  logic [WW-1:0]        cur_w_i,
   input  logic [PW-1:0]        pitch_i,
   input  logic                 mono_i,
   output logic                 show_o,
   output logic [CW:0]          dst_off_o,
   output logic [1:0]           pitch_code_o,
   output logic                 pitch_err_o,
   output logic [2:0]           lpc_code_o
);
   if (CW < 4 || AW < 1) begin : g_bad_top
      $error("cursor_cfg: parameter out of range");
   end

   logic [CW:0] dst_nxt;
   logic        in_view;
   logic [1:0]  pitch_nxt;
   logic        err_nxt;
   logic [2:0]  lpc_nxt;
   logic        addr_set;

   assign addr_set = |surf_addr_i;

   cursor_edge_cull #(.CW(CW), .WW(WW)) u_cull (
      .pos_x   (pos_x_i),
      .hot_x   (hot_x_i),
      .vp_x    (vp_x_i),
      .vp_w    (vp_w_i),
      .cur_w   (cur_w_i),
      .dst_off (dst_nxt),
      .in_view (in_view)
   );

   cursor_fetch_enc #(.WW(WW), .PW(PW)) u_enc (
      .cur_w      (cur_w_i),
      .pitch      (pitch_i),
      .mono       (mono_i),
      .pitch_code (pitch_nxt),
      .pitch_err  (err_nxt),
      .lpc_code   (lpc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         show_o       <= 1'b0;
         dst_off_o    <= '0;
         pitch_code_o <= '0;
         pitch_err_o  <= 1'b0;
         lpc_code_o   <= '0;
      end else if (commit_i) begin
         show_o       <= en_i && in_view && addr_set;
         if (addr_set) dst_off_o <= dst_nxt;
         pitch_code_o <= pitch_nxt;
         pitch_err_o  <= err_nxt;
         lpc_code_o   <= lpc_nxt;
      end
   end
endmodule

// File: rtl/cursor_cfg_chk.sv
module cursor_cfg_chk #(
   parameter int CW = 13,
   parameter int WW = 9,
   parameter int PW = 9,
   parameter int AW = 48
) (
   input logic          clk,
   input logic          rst_n,
   input logic          commit_i,
   input logic          en_i,
   input logic [AW-1:0] surf_addr_i,
   input logic [WW-1:0] cur_w_i,
   input logic [PW-1:0] pitch_i,
   input logic          mono_i,
   input logic          show_o,
   input logic [CW:0]   dst_off_o,
   input logic [1:0]    pitch_code_o,
   input logic          pitch_err_o,
   input logic [2:0]    lpc_code_o
);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(show_o) && $stable(dst_off_o) && $stable(pitch_code_o)
                    && $stable(pitch_err_o) && $stable(lpc_code_o));

   assert_sw_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && !en_i |=> !show_o);

   assert_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && (surf_addr_i == '0) |=> !show_o && $stable(dst_off_o));

   assert_pitch128_R8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && (pitch_i == PW'(128)) |=> (pitch_code_o == 2'd1) && !pitch_err_o);

   assert_mono_lpc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && mono_i |=> lpc_code_o == 3'd4);

   assert_wide_lpc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && !mono_i && ({1'b0, cur_w_i} > (WW+1)'(128)) |=> lpc_code_o == 3'd1);
endmodule

bind cursor_cfg cursor_cfg_chk #(.CW(CW), .WW(WW), .PW(PW), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .commit_i     (commit_i),
   .en_i         (en_i),
   .surf_addr_i  (surf_addr_i),
   .cur_w_i      (cur_w_i),
   .pitch_i      (pitch_i),
   .mono_i       (mono_i),
   .show_o       (show_o),
   .dst_off_o    (dst_off_o),
   .pitch_code_o (pitch_code_o),
   .pitch_err_o  (pitch_err_o),
   .lpc_code_o   (lpc_code_o)
);

// File: tb/test_cursor_cfg.sv
`timescale 1ns/1ps
module test_cursor_cfg;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               commit_i = 1'b0;
   logic               en_i = 1'b0;
   logic [47:0]        surf_addr_i = '0;
   logic signed [12:0] pos_x_i = '0;
   logic signed [12:0] hot_x_i = '0;
   logic signed [12:0] vp_x_i = '0;
   logic [12:0]        vp_w_i = '0;
   logic [8:0]         cur_w_i = '0;
   logic [8:0]         pitch_i = '0;
   logic               mono_i = 1'b0;
   logic               show_o;
   logic [13:0]        dst_off_o;
   logic [1:0]         pitch_code_o;
   logic               pitch_err_o;
   logic [2:0]         lpc_code_o;

   typedef struct {
      logic        show;
      logic [13:0] dst;
      logic [1:0]  pcode;
      logic        perr;
      logic [2:0]  lpc;
      string       tag;
   } exp_t;

   exp_t sb[$];
   exp_t last_exp;
   int   n_chk = 0;
   int   n_fail = 0;
   int   last_dst = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   cursor_cfg i_cursor_cfg (
      .clk (clk), .rst_n (rst_n), .commit_i (commit_i), .en_i (en_i),
      .surf_addr_i (surf_addr_i), .pos_x_i (pos_x_i), .hot_x_i (hot_x_i),
      .vp_x_i (vp_x_i), .vp_w_i (vp_w_i), .cur_w_i (cur_w_i), .pitch_i (pitch_i),
      .mono_i (mono_i), .show_o (show_o), .dst_off_o (dst_off_o),
      .pitch_code_o (pitch_code_o), .pitch_err_o (pitch_err_o), .lpc_code_o (lpc_code_o)
   );

   task automatic compare(input exp_t e);
      n_chk++;
      if (show_o !== e.show || dst_off_o !== e.dst || pitch_code_o !== e.pcode
          || pitch_err_o !== e.perr || lpc_code_o !== e.lpc) begin
         n_fail++;
         $display("FAIL %s: act show=%0d dst=%0d pc=%0d perr=%0d lpc=%0d exp show=%0d dst=%0d pc=%0d perr=%0d lpc=%0d",
                  e.tag, show_o, dst_off_o, pitch_code_o, pitch_err_o, lpc_code_o,
                  e.show, e.dst, e.pcode, e.perr, e.lpc);
      end
   endtask

   // driver: compute expectation from the requirements, push, then strobe
   task automatic apply(input int x, input int hx, input int vx, input int vw,
                        input int w, input int p, input bit mono, input bit en,
                        input logic [47:0] addr, input string tag);
      exp_t e;
      int   src;
      bit   vis;
      @(negedge clk);
      pos_x_i = 13'(x); hot_x_i = 13'(hx); vp_x_i = 13'(vx);
      vp_w_i = 13'(vw); cur_w_i = 9'(w); pitch_i = 9'(p);
      mono_i = mono; en_i = en; surf_addr_i = addr;
      src = x - hx - vx;                                  // R3
      vis = (src < vw) && (src + w >= 0);                 // R4 R5
      e.show = en && vis && (addr != 0);                  // R6 R7
      if (addr != 0) last_dst = (src < 0) ? 0 : src;      // R7 hold
      e.dst = 14'(last_dst);
      case (p)                                            // R8
         64:  begin e.pcode = 2'd0; e.perr = 1'b0; end
         128: begin e.pcode = 2'd1; e.perr = 1'b0; end
         256: begin e.pcode = 2'd2; e.perr = 1'b0; end
         default: begin e.pcode = 2'd0; e.perr = 1'b1; end
      endcase
      if (mono)        e.lpc = 3'd4;                       // R9
      else if (w <= 32)  e.lpc = 3'd4;                     // R10
      else if (w <= 64)  e.lpc = 3'd3;
      else if (w <= 128) e.lpc = 3'd2;
      else               e.lpc = 3'd1;
      e.tag = tag;
      sb.push_back(e);
      last_exp = e;
      commit_i = 1'b1;
      @(negedge clk);
      commit_i = 1'b0;
   endtask

   // monitor: pop on each commit edge, sample away from the edge
   initial begin
      forever begin
         @(posedge clk);
         if (commit_i) begin
            #5;
            if (sb.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R2: result with no expected item");
            end else compare(sb.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      exp_t z;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      z.show = 0; z.dst = 0; z.pcode = 0; z.perr = 0; z.lpc = 0; z.tag = "R1 reset";
      compare(z);

      apply(100, 4, 0, 1920, 64, 64, 0, 1, 48'h1000, "R3 R10 basic w64");
      apply(10, 20, 0, 1920, 32, 128, 0, 1, 48'h1000, "R3 negative clamp w32");
      apply(-50, 10, -100, 1920, 16, 256, 0, 1, 48'h1000, "R3 negative coords");
      apply(0, 0, 64, 1920, 64, 64, 0, 1, 48'h2000, "R5 left sum zero visible");
      apply(0, 1, 64, 1920, 64, 64, 0, 1, 48'h2000, "R5 left sum negative hidden");
      apply(899, 0, 100, 800, 65, 64, 0, 1, 48'h2000, "R4 right edge last visible");
      apply(900, 0, 100, 800, 128, 64, 0, 1, 48'h2000, "R4 right edge hidden");
      apply(300, 0, 0, 800, 129, 64, 0, 0, 48'h2000, "R6 software disable");
      apply(500, 0, 0, 800, 200, 256, 0, 1, 48'h0, "R7 zero address");
      apply(500, 0, 0, 800, 200, 100, 0, 1, 48'h3000, "R8 illegal pitch");
      apply(200, 0, 0, 800, 256, 128, 1, 1, 48'h3000, "R9 mono wide");
      apply(200, 0, 0, 800, 33, 128, 0, 1, 48'h3000, "R10 width 33");

      // R2: inputs move without a commit, outputs must hold
      @(negedge clk);
      pos_x_i = 13'd5; cur_w_i = 9'd300; pitch_i = 9'd7; en_i = 1'b0;
      surf_addr_i = '0; mono_i = 1'b1;
      repeat (3) @(negedge clk);
      last_exp.tag = "R2 hold without commit";
      compare(last_exp);

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R2: %0d expected items never produced (exp 0)", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule